// File: doc/BRIEF.md
# Three-Phase Motor PWM Generator

This block produces gate drive for a brushless DC motor inverter. One carrier counter, shared by all three phases, runs either as a triangle (counting up to the period value and back down) or as a sawtooth (counting up and wrapping). Each phase compares the carrier against its own duty value. The result drives a complementary upper/lower switch pair, so the block has six gate outputs. All three phases have the same frequency.

Software programs the block through a small write port. The period and the three duty values are written into shadow registers. The carrier copies them into its working copies together, on a period boundary. A programmable dead time keeps both switches of a pair off for a number of clocks whenever the pair changes state. A polarity bit selects active-low or active-high gate levels. An emergency-stop input drives all six gates to their inactive level at once. The stop then stays latched until software clears it.

Top module: `mpwm3`

## Requirements
- R1: With control bit 0 = 1 (sawtooth), the carrier counts 0 up to P-1 and wraps, so one PWM cycle lasts P clocks. An upper gate is raw-on while the carrier is below its duty value C, and it is active for C-D clocks per cycle, where D is the dead time.
- R2: With control bit 0 = 0 (triangle, the reset value), the carrier counts 0 up to P and back down to 1, so one cycle lasts 2P clocks. The upper gate is active for 2C-1-D clocks per cycle, and the lower gate for 2P-2C+1-D clocks.
- R3: A period written to address 0 takes effect only at the next boundary: the sawtooth wrap, or the triangle reaching zero. The cycle that is already running keeps its old length.
- R4: Duty values written to addresses 1, 2 and 3 (phases U, V and W, gate bit 0, 1 and 2) become active on the same boundary as the period.
- R5: A duty value of 0 keeps the upper gate inactive and the lower gate continuously active. A duty value of P or more keeps the upper gate continuously active and the lower gate inactive, with no dead-time gaps in either case.
- R6: Each gate turns on only D clocks after its partner turns off, with D taken from address 5. The upper and lower gates of a pair are never active together. With D = 0 a pair switches without a gap.
- R7: Control bit 1 selects the gate level: 0 (the reset value) means active-low and 1 means active-high. While reset is held, all six gates are high.
- R8: While the stop input is high, all six gates sit at their inactive level in the same cycle.
- R9: The stop condition is latched. The gates stay inactive after the input falls, until a write to address 4 with bit 2 = 1 arrives while the input is low. Such a write made while the input is high has no effect.
- R10: Writes to addresses 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 period, 1-3 duty U/V/W, 4 control, 5 dead time) |
| wr_data | input | CW | Write data |
| estop_in | input | 1 | Emergency-stop request, active high |
| gate_hi | output | 3 | Upper gates U, V, W |
| gate_lo | output | 3 | Lower gates (partners of U, V, W) |

## Verification
The bench counts, over exactly one PWM cycle, how many clocks each of the six gates is active. It does this for staggered duty values in sawtooth and in triangle mode; the two modes give different count formulas, so a wrong carrier shape or off-by-one compare shows up at once. Duty values of zero, exactly P and above P separate correct saturation from a missing cycle at the triangle peak. A run with zero dead time and active-high polarity tells inverted levels apart from timing errors. Rising-edge spacing and pulse widths measured around a mid-cycle period and duty write show whether the shadow copies load early, and zero-count windows during and after a stop show whether the latch and its clear rule hold.

// File: rtl/mpwm3.sv
module mpwm3 #(
  parameter int CW  = 12,
  parameter int DTW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          estop_in,
  output logic [2:0]    gate_hi,
  output logic [2:0]    gate_lo
);
  localparam logic [2:0] A_PER = 3'd0;
  localparam logic [2:0] A_CTL = 3'd4;
  localparam logic [2:0] A_DT  = 3'd5;

  logic [CW-1:0]        per_buf, per_act, cnt;
  logic [2:0][CW-1:0]   cmp_buf, cmp_act;
  logic [DTW-1:0]       dt;
  logic                 saw, pol, down, stop_lat, bnd;
  logic [2:0]           raw, on_hi, on_lo;
  logic [CW:0]          cnt_inc;

  wire clr_wr   = wr_en && wr_addr == A_CTL && wr_data[2];
  wire stop_any = estop_in | stop_lat;

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign bnd     = saw ? (cnt_inc >= {1'b0, per_act}) : (down && cnt <= 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_buf <= '0;
      cmp_buf <= '0;
      saw     <= 1'b0;
      pol     <= 1'b0;
      dt      <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_PER:               per_buf <= wr_data;
        3'd1, 3'd2, 3'd3:    cmp_buf[wr_addr - 3'd1] <= wr_data;
        A_CTL:               begin saw <= wr_data[0]; pol <= wr_data[1]; end
        A_DT:                dt <= wr_data[DTW-1:0];
        default:             ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      down    <= 1'b0;
      per_act <= '0;
      cmp_act <= '0;
    end else if (bnd) begin
      cnt     <= '0;
      down    <= 1'b0;
      per_act <= per_buf;
      cmp_act <= cmp_buf;
    end else if (saw) begin
      cnt  <= cnt_inc[CW-1:0];
      down <= 1'b0;
    end else if (down) begin
      cnt <= cnt - 1'b1;
    end else begin
      cnt <= cnt_inc[CW-1:0];
      if (cnt_inc >= {1'b0, per_act}) down <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        stop_lat <= 1'b0;
    else if (estop_in) stop_lat <= 1'b1;
    else if (clr_wr)   stop_lat <= 1'b0;
  end

  for (genvar i = 0; i < 3; i++) begin : g_ph
    logic           lvl;
    logic [DTW-1:0] dcnt;

    assign raw[i] = (cmp_act[i] != '0) &&
                    ((cmp_act[i] >= per_act) || (cnt < cmp_act[i]));

    // dcnt resets to 1 so the lower gate also stays off while reset is held
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lvl  <= 1'b0;
        dcnt <= DTW'(1);
      end else if (raw[i] != lvl) begin
        lvl  <= raw[i];
        dcnt <= dt;
      end else if (dcnt != '0) begin
        dcnt <= dcnt - 1'b1;
      end
    end

    assign on_hi[i] =  lvl && dcnt == '0 && !stop_any;
    assign on_lo[i] = !lvl && dcnt == '0 && !stop_any;
  end

  assign gate_hi = pol ? on_hi : ~on_hi;
  assign gate_lo = pol ? on_lo : ~on_lo;
endmodule

module mpwm3_chk #(
  parameter int CW  = 12,
  parameter int DTW = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               estop_in,
  input logic               pol,
  input logic [DTW-1:0]     dt,
  input logic [CW-1:0]      cnt,
  input logic [CW-1:0]      per_act,
  input logic [2:0][CW-1:0] cmp_act,
  input logic [2:0]         gate_hi,
  input logic [2:0]         gate_lo
);
  logic [2:0] act_hi, act_lo;
  assign act_hi = pol ? gate_hi : ~gate_hi;
  assign act_lo = pol ? gate_lo : ~gate_lo;

  for (genvar i = 0; i < 3; i++) begin : g_a
    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(act_hi[i] && act_lo[i]));
    p_dead_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(act_hi[i]) && $past(dt) >= 2) |=> !act_lo[i]);
  end

  p_stop_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
    estop_in |-> (act_hi == 3'b000 && act_lo == 3'b000));

  p_stop_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(estop_in)) |-> (act_hi == 3'b000 && act_lo == 3'b000));

  p_per_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(per_act) |-> cnt == '0);

  p_cmp_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmp_act) |-> cnt == '0);
endmodule

bind mpwm3 mpwm3_chk #(.CW(CW), .DTW(DTW)) chk_i (
  .clk(clk), .rst_n(rst_n), .estop_in(estop_in), .pol(pol), .dt(dt),
  .cnt(cnt), .per_act(per_act), .cmp_act(cmp_act),
  .gate_hi(gate_hi), .gate_lo(gate_lo)
);

// File: tb/mpwm3_tb.sv
module mpwm3_tb_top;
  localparam int CW  = 12;
  localparam int DTW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic          estop_in = 1'b0;
  logic [2:0]    gate_hi, gate_lo;

  always #2.5 clk = ~clk;

  mpwm3 #(.CW(CW), .DTW(DTW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .estop_in(estop_in), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  typedef struct {
    string tag;
    int    win;
    bit    pol;
    int    hi[3];
    int    lo[3];
  } item_t;

  item_t exp_q[$];
  int    pend  = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  bit    cur_pol = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d[CW-1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_win(input string tag, input int win,
                            input int h0, input int h1, input int h2,
                            input int l0, input int l1, input int l2);
    item_t it;
    it.tag = tag; it.win = win; it.pol = cur_pol;
    it.hi[0] = h0; it.hi[1] = h1; it.hi[2] = h2;
    it.lo[0] = l0; it.lo[1] = l1; it.lo[2] = l2;
    exp_q.push_back(it);
    pend++;
    wait (pend == 0);
  endtask

  // monitor: measures active clocks of every gate over one PWM cycle
  initial begin
    item_t it;
    int ch[3], cl[3];
    forever begin
      wait (pend > 0);
      it = exp_q.pop_front();
      for (int i = 0; i < 3; i++) begin ch[i] = 0; cl[i] = 0; end
      repeat (it.win) begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
          if ((it.pol ? gate_hi[i] : ~gate_hi[i]) == 1'b1) ch[i]++;
          if ((it.pol ? gate_lo[i] : ~gate_lo[i]) == 1'b1) cl[i]++;
        end
      end
      for (int i = 0; i < 3; i++) begin
        check(ch[i] == it.hi[i], $sformatf("%s upper phase %0d", it.tag, i), ch[i], it.hi[i]);
        check(cl[i] == it.lo[i], $sformatf("%s lower phase %0d", it.tag, i), cl[i], it.lo[i]);
      end
      pend--;
    end
  end

  task automatic wait_u(input bit level);
    do @(negedge clk); while ((cur_pol ? gate_hi[0] : ~gate_hi[0]) != level);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int t0, t1, t2, f0, f1;
    settle(3);
    check(gate_hi == 3'b111 && gate_lo == 3'b111, "R7 reset level", {gate_hi, gate_lo}, 6'h3f);
    @(negedge clk) rst_n = 1'b1;
    settle(10);
    check(gate_hi == 3'b111, "R5 zero duty after reset upper", gate_hi, 3'b111);
    check(gate_lo == 3'b000, "R5 zero duty after reset lower", gate_lo, 3'b000);

    // sawtooth, staggered duties, dead time 2
    wr(4, 1); wr(0, 20); wr(1, 5); wr(2, 10); wr(3, 15); wr(5, 2);
    settle(100);
    expect_win("R1 sawtooth", 20, 3, 8, 13, 13, 8, 3);

    // triangle
    wr(4, 0);
    settle(150);
    expect_win("R2 triangle", 40, 7, 17, 27, 29, 19, 9);

    // saturation in triangle mode
    wr(1, 0); wr(2, 20); wr(3, 30); wr(5, 3);
    settle(150);
    expect_win("R5 saturation", 40, 0, 40, 40, 40, 0, 0);

    // active-high, zero dead time
    wr(4, 3); cur_pol = 1'b1;
    wr(0, 16); wr(1, 4); wr(2, 8); wr(3, 12); wr(5, 0);
    settle(100);
    expect_win("R6 R7 no gap active-high", 16, 4, 8, 12, 12, 8, 4);

    // emergency stop
    wr(4, 1); cur_pol = 1'b0;
    wr(0, 20); wr(1, 5); wr(2, 10); wr(3, 15); wr(5, 2);
    settle(100);
    expect_win("R1 restore", 20, 3, 8, 13, 13, 8, 3);
    @(negedge clk) estop_in = 1'b1;
    #1;
    check(gate_hi == 3'b111 && gate_lo == 3'b111, "R8 immediate stop", {gate_hi, gate_lo}, 6'h3f);
    expect_win("R8 stop held", 20, 0, 0, 0, 0, 0, 0);
    @(negedge clk) estop_in = 1'b0;
    settle(2);
    expect_win("R9 latched", 20, 0, 0, 0, 0, 0, 0);
    @(negedge clk) estop_in = 1'b1;
    wr(4, 5);
    @(negedge clk) estop_in = 1'b0;
    settle(2);
    expect_win("R9 clear while high ignored", 20, 0, 0, 0, 0, 0, 0);
    wr(4, 5);
    settle(100);
    expect_win("R9 resume after clear", 20, 3, 8, 13, 13, 8, 3);

    // shadow loading of period and duty
    wr(5, 0); wr(1, 10);
    settle(100);
    wait_u(1'b0); wait_u(1'b1); t0 = cyc;
    wr(0, 30); wr(1, 15);
    wait_u(1'b0); f0 = cyc;
    check(f0 - t0 == 10, "R4 duty held in running cycle", f0 - t0, 10);
    wait_u(1'b1); t1 = cyc;
    check(t1 - t0 == 20, "R3 period held in running cycle", t1 - t0, 20);
    wait_u(1'b0); f1 = cyc;
    check(f1 - t1 == 15, "R4 new duty after boundary", f1 - t1, 15);
    wait_u(1'b1); t2 = cyc;
    check(t2 - t1 == 30, "R3 new period after boundary", t2 - t1, 30);

    // unused addresses
    wr(6, 0); wr(7, 2);
    settle(80);
    expect_win("R10 unused addresses", 30, 15, 10, 15, 15, 20, 15);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule